// File: doc/BRIEF.md
# Toggle-Strobed Byte Port Receiver

This block is the device end of a byte-wide parallel link driven by a slow controller that has no clock of its own on the link. The controller never drives edge-qualified clocks. It flips a strobe line instead, and every change of level, upward or downward, marks one byte. All control lines arrive asynchronously. They are brought into the local clock through two-stage synchronizers, and events are found by comparing each synchronized sample with the one taken a cycle earlier.

In the write direction the controller raises a framing line, presents bytes on the data bus and flips the write strobe once per byte, then lowers the framing line. The received bytes are placed least significant byte first into a wide receive register. The lowering of the framing line raises a one-cycle valid pulse. In the read direction a start pulse copies a wide word from the core into a shadow register. The lowest byte is then on the byte output at once. Each flip of the read strobe moves the output to the next byte, and the position wraps after the last one. Strobe levels are never reset between bursts, so a burst may begin on either level.

Top module: `tsb_port`

## Requirements
- R1: After reset the receive word is zero, the valid pulse is low and the byte output is zero.
- R2: While the framing line is high, each write strobe level change stores the data bus byte. The k-th byte of a burst (k counted from 0) lands in bits [8*(k mod NB)+7 : 8*(k mod NB)], where NB = WORD_W/8, so a burst longer than NB bytes wraps and overwrites from the low byte.
- R3: Rising and falling write strobe changes both transfer a byte. A burst may start from either strobe level.
- R4: A rising framing line clears the receive word to zero before the first byte of the burst.
- R5: A falling framing line gives exactly one cycle of valid. At that time, and until the next rising framing line, the receive word holds the burst's bytes.
- R6: Write strobe changes while the framing line is low leave the receive word unchanged.
- R7: A rising start line copies the read word into the shadow register. Byte 0 is on the byte output before any read strobe change. Later changes of the read word input do not affect the output until the next start.
- R8: Each read strobe level change, in either direction, moves the byte output from byte i to byte i+1 of the shadow register. After byte NB-1 it returns to byte 0.
- R9: When a start event and a read strobe change reach the local clock in the same cycle, the start takes precedence and the output shows byte 0 of the new word.
- R10: When the last write strobe change and the falling framing line reach the local clock in the same cycle, that byte is included in the word reported with the valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Asynchronous write framing line, high for the duration of a burst |
| wr_tgl_i | input | 1 | Asynchronous write strobe, each level change is one byte |
| wr_byte_i | input | 8 | Write data byte, held stable by the controller around each strobe change |
| rd_start_i | input | 1 | Asynchronous read start pulse |
| rd_tgl_i | input | 1 | Asynchronous read strobe, each level change advances one byte |
| rd_word_i | input | WORD_W | Word offered by the core for reading |
| rx_word_o | output | WORD_W | Assembled receive word |
| rx_valid_o | output | 1 | One-cycle pulse after the framing line falls |
| tx_byte_o | output | 8 | Currently selected byte of the read shadow word |

## Verification
Two pairs of functions can fall in the same local cycle. The first is a final write strobe change and the closing of the frame. The second is a read start and a read strobe change. The bench provokes each by changing both asynchronous lines at the same falling clock edge. Because the lines pass through identical synchronizers, the two events are detected together. The write case is judged by requiring the final byte in the word seen alongside the valid pulse. The read case is judged by requiring byte 0 of the freshly loaded word on the output.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  // true when a synchronized level differs from its previous sample
  function automatic logic tsb_changed(input logic cur, input logic prev);
    return cur ^ prev;
  endfunction

  // true on a low-to-high step of a synchronized level
  function automatic logic tsb_rose(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // byte position that follows idx in a word of nbytes bytes, wrapping
  function automatic int unsigned tsb_idx_next(input int unsigned idx,
                                               input int unsigned nbytes);
    return (idx + 1 >= nbytes) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/tsb_sync.sv
module tsb_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/tsb_wr_asm.sv
module tsb_wr_asm
  import tsb_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  localparam int unsigned NB    = WORD_W / 8,
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_rise,
  input  logic              frame_fall,
  input  logic              frame_open,
  input  logic              wr_evt,
  input  logic [7:0]        wr_byte,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] word_q, word_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              valid_q;

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    if (frame_rise) begin
      word_d = '0;
      idx_d  = '0;
    end
    if (wr_evt && frame_open) begin
      word_d[idx_d*8 +: 8] = wr_byte;
      idx_d = IDX_W'(tsb_idx_next(32'(idx_d), NB));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      idx_q   <= idx_d;
      valid_q <= frame_fall;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/tsb_rd_sel.sv
module tsb_rd_sel
  import tsb_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  localparam int unsigned NB    = WORD_W / 8,
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              rd_evt,
  input  logic [WORD_W-1:0] rd_word,
  output logic [7:0]        byte_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [WORD_W-1:0] shadow_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      idx_q    <= '0;
    end else if (start_evt) begin
      shadow_q <= rd_word;
      idx_q    <= '0;
    end else if (rd_evt) begin
      idx_q <= IDX_W'(tsb_idx_next(32'(idx_q), NB));
    end
  end

  assign byte_o = shadow_q[idx_q*8 +: 8];
  assign idx_o  = idx_q;
endmodule

// File: rtl/tsb_port.sv
module tsb_port
  import tsb_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NB    = WORD_W / 8,
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic              wr_tgl_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              rd_start_i,
  input  logic              rd_tgl_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic [7:0]        tx_byte_o
);
  localparam int unsigned L_FRAME = 0;
  localparam int unsigned L_WR    = 1;
  localparam int unsigned L_START = 2;
  localparam int unsigned L_RD    = 3;

  logic [3:0] async_vec, lvl, prev;

  // named internal events, observed by the bound checker
  logic frame_lvl, frame_prev, frame_rise, frame_fall, frame_open;
  logic wr_evt, start_evt, rd_evt;
  logic [IDX_W-1:0] rd_idx;

  assign async_vec = {rd_tgl_i, rd_start_i, wr_tgl_i, frame_i};

  tsb_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_vec),
    .lvl_o   (lvl),
    .prev_o  (prev)
  );

  assign frame_lvl  = lvl[L_FRAME];
  assign frame_prev = prev[L_FRAME];
  assign frame_rise = tsb_rose(lvl[L_FRAME], prev[L_FRAME]);
  assign frame_fall = tsb_rose(prev[L_FRAME], lvl[L_FRAME]);
  assign frame_open = frame_lvl | frame_prev;
  assign wr_evt     = tsb_changed(lvl[L_WR], prev[L_WR]);
  assign start_evt  = tsb_rose(lvl[L_START], prev[L_START]);
  assign rd_evt     = tsb_changed(lvl[L_RD], prev[L_RD]);

  tsb_wr_asm #(.WORD_W(WORD_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_rise (frame_rise),
    .frame_fall (frame_fall),
    .frame_open (frame_open),
    .wr_evt     (wr_evt),
    .wr_byte    (wr_byte_i),
    .word_o     (rx_word_o),
    .valid_o    (rx_valid_o)
  );

  tsb_rd_sel #(.WORD_W(WORD_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .rd_evt    (rd_evt),
    .rd_word   (rd_word_i),
    .byte_o    (tx_byte_o),
    .idx_o     (rd_idx)
  );
endmodule

// File: rtl/tsb_port_chk.sv
module tsb_port_chk #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_lvl,
  input logic              frame_prev,
  input logic              frame_rise,
  input logic              frame_fall,
  input logic              wr_evt,
  input logic              start_evt,
  input logic              rd_evt,
  input logic              rx_valid_o,
  input logic [WORD_W-1:0] rx_word_o,
  input logic [7:0]        tx_byte_o,
  input logic [IDX_W-1:0]  rd_idx
);
  // R5: valid lasts a single cycle
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R5: a closing frame always yields valid next cycle
  a_r5_valid_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fall |=> rx_valid_o);

  // R6: with the frame closed the receive word does not move
  a_r6_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_lvl && !frame_prev) |=> $stable(rx_word_o));

  // R4: opening a frame without a byte leaves an all-zero word
  a_r4_open_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rise && !wr_evt) |=> (rx_word_o == '0));

  // R7 / R9: a start event selects byte 0
  a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (rd_idx == '0));

  // R8: without read events the byte output is steady
  a_r8_idle_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && !rd_evt) |=> $stable(tx_byte_o));
endmodule

bind tsb_port tsb_port_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_lvl  (frame_lvl),
  .frame_prev (frame_prev),
  .frame_rise (frame_rise),
  .frame_fall (frame_fall),
  .wr_evt     (wr_evt),
  .start_evt  (start_evt),
  .rd_evt     (rd_evt),
  .rx_valid_o (rx_valid_o),
  .rx_word_o  (rx_word_o),
  .tx_byte_o  (tx_byte_o),
  .rd_idx     (rd_idx)
);

// File: tb/tsb_port_tb.sv
module tsb_port_tb;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned NB     = WORD_W / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_i = 1'b0;
  logic              wr_tgl_i = 1'b0;
  logic [7:0]        wr_byte_i = 8'h00;
  logic              rd_start_i = 1'b0;
  logic              rd_tgl_i = 1'b0;
  logic [WORD_W-1:0] rd_word_i = '0;
  logic [WORD_W-1:0] rx_word_o;
  logic              rx_valid_o;
  logic [7:0]        tx_byte_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] bq [0:15];
  int nq = 0;

  always #4 clk = ~clk;

  tsb_port #(.WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .wr_tgl_i(wr_tgl_i),
    .wr_byte_i(wr_byte_i), .rd_start_i(rd_start_i), .rd_tgl_i(rd_tgl_i),
    .rd_word_i(rd_word_i), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o),
    .tx_byte_o(tx_byte_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected receive word from the bytes of the current burst
  function automatic logic [WORD_W-1:0] exp_word(input int n);
    logic [WORD_W-1:0] w = '0;
    for (int k = 0; k < n; k++) w[(k % NB)*8 +: 8] = bq[k];
    return w;
  endfunction

  function automatic logic [7:0] byte_of(input logic [WORD_W-1:0] w, input int i);
    return w[(i % NB)*8 +: 8];
  endfunction

  task automatic send_byte(input logic [7:0] b);
    wr_byte_i = b;
    idle(1);
    wr_tgl_i = ~wr_tgl_i;
    bq[nq] = b;
    nq++;
    idle(4);
  endtask

  // close the frame and watch the valid pulse
  task automatic close_and_check(input string req);
    int hi = 0;
    logic [WORD_W-1:0] seen = '0;
    frame_i = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (rx_valid_o) begin hi++; seen = rx_word_o; end
    end
    chk("R5 valid pulse width", 64'(hi), 64'd1);
    chk(req, seen, exp_word(nq));
    chk("R5 word held after valid", rx_word_o, exp_word(nq));
  endtask

  task automatic open_frame();
    frame_i = 1'b1;
    nq = 0;
    idle(5);
  endtask

  task automatic start_read(input logic [WORD_W-1:0] w);
    rd_word_i = w;
    idle(1);
    rd_start_i = 1'b1;
    idle(3);
    rd_start_i = 1'b0;
    idle(4);
  endtask

  initial begin
    logic [WORD_W-1:0] rw, rw2, held;
    int n;
    void'($urandom(32'h5eed_0042));
    idle(3);
    // R1: reset state
    chk("R1 rx_word reset", rx_word_o, '0);
    chk("R1 rx_valid reset", 64'(rx_valid_o), 64'd0);
    chk("R1 tx_byte reset", 64'(tx_byte_o), 64'd0);
    rst_n = 1'b1;
    idle(4);

    // R2/R4: directed burst, full word, starting from strobe low
    open_frame();
    chk("R4 word cleared on open", rx_word_o, '0);
    for (int k = 0; k < NB; k++) send_byte(8'(8'h11 * (k + 1)));
    close_and_check("R2 full burst lsb first");

    // R6: strobe changes outside a frame are ignored
    held = rx_word_o;
    for (int k = 0; k < 3; k++) begin
      wr_byte_i = 8'(k + 8'hA0);
      idle(1);
      wr_tgl_i = ~wr_tgl_i;
      idle(4);
    end
    chk("R6 word unchanged outside frame", rx_word_o, held);
    chk("R6 no valid outside frame", 64'(rx_valid_o), 64'd0);

    // R3: bursts starting from the high strobe level, then the low level
    wr_tgl_i = 1'b1; idle(5);
    open_frame();
    for (int k = 0; k < 3; k++) send_byte(8'($urandom));
    close_and_check("R3 burst from high strobe");
    wr_tgl_i = 1'b0; idle(5);
    open_frame();
    for (int k = 0; k < 5; k++) send_byte(8'($urandom));
    close_and_check("R3 burst from low strobe");

    // R4: a short burst after a long one leaves no stale bytes
    open_frame();
    chk("R4 cleared before short burst", rx_word_o, '0);
    send_byte(8'h5A);
    close_and_check("R4 single byte burst");

    // R2: overlong burst wraps
    open_frame();
    for (int k = 0; k < NB + 3; k++) send_byte(8'($urandom));
    close_and_check("R2 wrap on overlong burst");

    // R10: last strobe change and frame close in the same cycle
    open_frame();
    for (int k = 0; k < 2; k++) send_byte(8'($urandom));
    wr_byte_i = 8'hC3;
    idle(1);
    bq[nq] = 8'hC3; nq++;
    wr_tgl_i = ~wr_tgl_i;
    close_and_check("R10 coincident last byte included");

    // random bursts
    for (int t = 0; t < 12; t++) begin
      if ($urandom_range(0, 1) == 1) begin wr_tgl_i = ~wr_tgl_i; idle(5); end
      open_frame();
      n = $urandom_range(1, NB + 2);
      for (int k = 0; k < n; k++) send_byte(8'($urandom));
      close_and_check("R2 random burst");
    end

    // R7: read start loads word, byte 0 visible before any strobe
    rw = {$urandom, $urandom};
    start_read(rw);
    chk("R7 byte 0 after start", 64'(tx_byte_o), 64'(byte_of(rw, 0)));
    rd_word_i = ~rw;
    idle(5);
    chk("R7 shadow ignores later input", 64'(tx_byte_o), 64'(byte_of(rw, 0)));

    // R8: each change advances, wraps after last byte, both directions
    for (int i = 1; i <= NB + 2; i++) begin
      rd_tgl_i = ~rd_tgl_i;
      idle(5);
      chk("R8 read advance", 64'(tx_byte_o), 64'(byte_of(rw, i)));
    end

    // R9: start and read strobe change in the same cycle
    rw2 = {$urandom, $urandom};
    rd_word_i = rw2;
    idle(1);
    rd_start_i = 1'b1;
    rd_tgl_i = ~rd_tgl_i;
    idle(3);
    rd_start_i = 1'b0;
    idle(4);
    chk("R9 start wins over strobe", 64'(tx_byte_o), 64'(byte_of(rw2, 0)));
    rd_tgl_i = ~rd_tgl_i;
    idle(5);
    chk("R8 advance after coincident start", 64'(tx_byte_o), 64'(byte_of(rw2, 1)));

    // random reads
    for (int t = 0; t < 6; t++) begin
      rw = {$urandom, $urandom};
      start_read(rw);
      chk("R7 random start", 64'(tx_byte_o), 64'(byte_of(rw, 0)));
      n = $urandom_range(1, NB + 3);
      for (int i = 1; i <= n; i++) begin
        rd_tgl_i = ~rd_tgl_i;
        idle(5);
      end
      chk("R8 random advance", 64'(tx_byte_o), 64'(byte_of(rw, n)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule